// File: doc/BRIEF.md
# I2C Bus State Monitor

A passive observer for a two-wire I2C bus. It samples the SCL and SDA lines on a fast system clock through multi-stage synchronizers. It finds edges by comparing each synchronized sample with the one before it. It never drives either line. From these samples it recognizes START, repeated START and STOP conditions, keeps a bus-busy flag, and counts the bits and bytes of the transfer in progress.

A STOP that lands inside a byte ends the transfer and is reported as an aborted frame. An idle timer watches for both lines resting high. Once that has lasted the programmed number of system clock cycles, it forces the bus back to free even though no STOP arrived. Every event is a single-cycle pulse, so a controller, arbiter or debug logger sharing the bus can react without polling.

Top module: `i2c_bus_monitor`

## Requirements
- R1: An SDA fall while SCL is high on a free bus pulses `start_o`. It sets `busy_o`, clears `bit_cnt_o` to 0 and raises `addr_phase_o`.
- R2: The same SDA fall while `busy_o` is 1 pulses `rstart_o` instead of `start_o`. It keeps `busy_o` at 1, clears `bit_cnt_o` to 0 and raises `addr_phase_o`, so the next byte is an address byte.
- R3: An SDA rise while SCL is high pulses `stop_o`. It clears `busy_o`, `bit_cnt_o` and `addr_phase_o`. At most one of `start_o`, `rstart_o`, `stop_o` and `timeout_o` is high in any cycle.
- R4: A STOP that arrives while busy with `bit_cnt_o` not 0 also pulses `abort_o`, in the same cycle as `stop_o`. A STOP at a byte boundary leaves `abort_o` low.
- R5: While busy, each SCL high period that ends with a falling SCL adds one to `bit_cnt_o`. SDA is sampled at the rise. On the ninth bit (8 data bits plus acknowledge) the counter returns to 0, `byte_done_o` pulses and `addr_phase_o` drops.
- R6: SDA changes while SCL is low never alter `bit_cnt_o` and never produce an event.
- R7: When SCL and SDA have both been high for `idle_limit_i` consecutive system cycles while busy, `timeout_o` pulses once. In the same cycle `busy_o`, `bit_cnt_o` and `addr_phase_o` clear. A limit of 0 disables the timer.
- R8: SCL held low for any duration, as in clock stretching, neither times out nor changes `bit_cnt_o`. Counting resumes correctly afterwards.
- R9: After reset the bus is free, `bit_cnt_o` is 0, `addr_phase_o` is 0 and every event output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| idle_limit_i | input | TO_W | Bus-free timeout in system cycles, 0 disables |
| start_o | output | 1 | START on a free bus, one-cycle pulse |
| rstart_o | output | 1 | Repeated START, one-cycle pulse |
| stop_o | output | 1 | STOP seen, one-cycle pulse |
| abort_o | output | 1 | STOP inside a byte, pulses with stop_o |
| byte_done_o | output | 1 | Ninth bit of a frame completed, one-cycle pulse |
| timeout_o | output | 1 | Bus forced free by idle timer, one-cycle pulse |
| busy_o | output | 1 | Bus busy flag |
| addr_phase_o | output | 1 | Current byte is an address byte |
| bit_cnt_o | output | CNT_W | Bits completed in the current frame, 0 to 8 |

## Verification
The bench builds the monitor with its default parameters: two synchronizer stages, 8 data bits and a 16-bit timeout field. Because the timeout is a port, one build can program limits of 10, 25 and 0 cycles. A 4-cycle SCL phase keeps every legal high period well under the 10-cycle limit. Holding both lines high for 18 or 40 cycles then lands on either side of the threshold. A 400-cycle stretch shows that low SCL never counts toward the timeout, however long it lasts.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

  localparam int unsigned N_LINES = 2;
  localparam int unsigned LN_SCL  = 0;
  localparam int unsigned LN_SDA  = 1;

  typedef struct packed {
    logic scl;
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_evt_t;

endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int unsigned N      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] ff_q;
    // idle bus level is high, so reset to 1 to avoid false edges
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '1;
      else         ff_q <= {ff_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = ff_q[STAGES-1];
  end

endmodule

// File: rtl/i2c_mon_cond.sv
module i2c_mon_cond
  import i2c_mon_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SDA moves with SCL high on both samples: bus condition, not data
  always_comb begin
    evt_o.scl      = scl_i;
    evt_o.sda      = sda_i;
    evt_o.scl_rise = scl_i & ~scl_q;
    evt_o.scl_fall = ~scl_i & scl_q;
    evt_o.start    = scl_i & scl_q & sda_q & ~sda_i;
    evt_o.stop     = scl_i & scl_q & ~sda_q & sda_i;
  end

endmodule

// File: rtl/i2c_mon_idle.sv
module i2c_mon_idle #(
  parameter int unsigned TO_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            fire_o
);

  logic [TO_W-1:0] cnt_q;
  logic            both_hi, below;

  assign both_hi = scl_i & sda_i;
  assign below   = cnt_q < limit_i;
  assign fire_o  = both_hi & below & (({1'b0, cnt_q} + 1'b1) == {1'b0, limit_i});

  // saturates at the limit, so it fires once per idle stretch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!both_hi) cnt_q <= '0;
    else if (below)    cnt_q <= cnt_q + 1'b1;
  end

  AST_LOW_CLEARS_TIMER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scl_i |=> (cnt_q == '0)); // R8
  AST_FIRE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o); // R7

endmodule

// File: rtl/i2c_mon_frame.sv
module i2c_mon_frame
  import i2c_mon_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned CNT_W     = $clog2(DATA_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  bus_evt_t         evt_i,
  input  logic             fire_i,
  output logic             start_o,
  output logic             rstart_o,
  output logic             stop_o,
  output logic             abort_o,
  output logic             byte_done_o,
  output logic             timeout_o,
  output logic             busy_o,
  output logic             addr_phase_o,
  output logic [CNT_W-1:0] bit_cnt_o
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_BITS);

  logic             busy_q, pend_q, addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             force_free, commit, wrap;

  assign force_free = fire_i & busy_q;
  // a bit counts only when its high period ends with a fall, so the
  // SCL rise inside a STOP or repeated START never counts
  assign commit     = busy_q & pend_q & evt_i.scl_fall;
  assign wrap       = commit & (cnt_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      pend_q      <= 1'b0;
      addr_q      <= 1'b0;
      cnt_q       <= '0;
      start_o     <= 1'b0;
      rstart_o    <= 1'b0;
      stop_o      <= 1'b0;
      abort_o     <= 1'b0;
      byte_done_o <= 1'b0;
      timeout_o   <= 1'b0;
    end else begin
      start_o     <= evt_i.start & ~busy_q;
      rstart_o    <= evt_i.start & busy_q;
      stop_o      <= evt_i.stop;
      abort_o     <= evt_i.stop & busy_q & (cnt_q != '0);
      byte_done_o <= wrap;
      timeout_o   <= force_free;

      if (evt_i.start) begin
        busy_q <= 1'b1;
        pend_q <= 1'b0;
        addr_q <= 1'b1;
        cnt_q  <= '0;
      end else if (evt_i.stop || force_free) begin
        busy_q <= 1'b0;
        pend_q <= 1'b0;
        addr_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        if (busy_q && evt_i.scl_rise) pend_q <= 1'b1;
        else if (evt_i.scl_fall)      pend_q <= 1'b0;
        if (wrap) begin
          cnt_q  <= '0;
          addr_q <= 1'b0;
        end else if (commit) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o       = busy_q;
  assign addr_phase_o = addr_q;
  assign bit_cnt_o    = cnt_q;

  AST_START_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o && addr_phase_o && bit_cnt_o == '0); // R1
  AST_RSTART_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rstart_o |-> $past(busy_o) && busy_o && addr_phase_o); // R2
  AST_STOP_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> !busy_o && bit_cnt_o == '0); // R3
  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, rstart_o, stop_o, timeout_o})); // R3
  AST_ABORT_WITH_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> stop_o); // R4
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_o <= LAST_BIT); // R5
  AST_BYTE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |-> bit_cnt_o == '0 && !addr_phase_o); // R5
  AST_TIMEOUT_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !busy_o && $past(busy_o)); // R7

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2c_mon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned TO_W        = 16,
  parameter int unsigned CNT_W       = $clog2(DATA_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [TO_W-1:0]  idle_limit_i,
  output logic             start_o,
  output logic             rstart_o,
  output logic             stop_o,
  output logic             abort_o,
  output logic             byte_done_o,
  output logic             timeout_o,
  output logic             busy_o,
  output logic             addr_phase_o,
  output logic [CNT_W-1:0] bit_cnt_o
);

  logic [N_LINES-1:0] raw, synced;
  bus_evt_t           evt;
  logic               fire;

  assign raw[LN_SCL] = scl_i;
  assign raw[LN_SDA] = sda_i;

  i2c_mon_sync #(.N(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  i2c_mon_cond u_cond (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (synced[LN_SCL]),
    .sda_i (synced[LN_SDA]),
    .evt_o (evt)
  );

  i2c_mon_idle #(.TO_W(TO_W)) u_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (synced[LN_SCL]),
    .sda_i  (synced[LN_SDA]),
    .limit_i(idle_limit_i),
    .fire_o (fire)
  );

  i2c_mon_frame #(.DATA_BITS(DATA_BITS), .CNT_W(CNT_W)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .fire_i      (fire),
    .start_o     (start_o),
    .rstart_o    (rstart_o),
    .stop_o      (stop_o),
    .abort_o     (abort_o),
    .byte_done_o (byte_done_o),
    .timeout_o   (timeout_o),
    .busy_o      (busy_o),
    .addr_phase_o(addr_phase_o),
    .bit_cnt_o   (bit_cnt_o)
  );

endmodule

// File: tb/sim_i2c_bus_monitor.sv
module sim_i2c_bus_monitor;

  localparam int Q = 4;

  typedef enum int {EV_START, EV_RSTART, EV_STOP, EV_ABORT, EV_BYTE, EV_TIMEOUT} ev_e;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        scl_r = 1'b1;
  logic        sda_r = 1'b1;
  logic [15:0] limit_r = 16'd10;
  logic        start_o, rstart_o, stop_o, abort_o, byte_done_o, timeout_o;
  logic        busy_o, addr_phase_o;
  logic [3:0]  bit_cnt_o;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  ev_e exp_q[$];

  always #10 clk_i = ~clk_i;

  i2c_bus_monitor u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_r), .sda_i(sda_r),
    .idle_limit_i(limit_r),
    .start_o(start_o), .rstart_o(rstart_o), .stop_o(stop_o), .abort_o(abort_o),
    .byte_done_o(byte_done_o), .timeout_o(timeout_o), .busy_o(busy_o),
    .addr_phase_o(addr_phase_o), .bit_cnt_o(bit_cnt_o)
  );

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  task automatic pop_cmp(ev_e got);
    n_checks++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL event order: actual=%s expected=none", got.name());
    end else begin
      ev_e e = exp_q.pop_front();
      if (e != got) begin
        n_fail++;
        $display("FAIL event order: actual=%s expected=%s", got.name(), e.name());
      end
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (start_o)     pop_cmp(EV_START);
      if (rstart_o)    pop_cmp(EV_RSTART);
      if (byte_done_o) pop_cmp(EV_BYTE);
      if (stop_o)      pop_cmp(abort_o ? EV_ABORT : EV_STOP);
      if (abort_o && !stop_o) pop_cmp(EV_ABORT);
      if (timeout_o)   pop_cmp(EV_TIMEOUT);
    end
  end

  task automatic hold(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic put(ev_e e);
    exp_q.push_back(e);
  endtask

  task automatic do_start();
    sda_r = 1'b1; hold(Q);
    scl_r = 1'b1; hold(Q);
    sda_r = 1'b0; hold(Q);
    scl_r = 1'b0; hold(Q);
  endtask

  task automatic do_bit(logic b);
    sda_r = b;    hold(Q);
    scl_r = 1'b1; hold(Q);
    scl_r = 1'b0; hold(Q);
  endtask

  task automatic do_byte(logic [7:0] v);
    put(EV_BYTE);
    for (int i = 7; i >= 0; i--) do_bit(v[i]);
    do_bit(1'b0);
  endtask

  task automatic do_stop();
    sda_r = 1'b0; hold(Q);
    scl_r = 1'b1; hold(Q);
    sda_r = 1'b1; hold(Q);
  endtask

  initial begin
    hold(3);
    // R9: reset state
    chk("R9 busy", busy_o, 0);
    chk("R9 bit_cnt", bit_cnt_o, 0);
    chk("R9 addr_phase", addr_phase_o, 0);
    chk("R9 events", {start_o, rstart_o, stop_o, abort_o, byte_done_o, timeout_o}, 0);
    rst_ni = 1'b1;
    hold(30);
    chk("R9 idle no timeout", busy_o, 0);

    // R1 R5 R3: simple write, two bytes, then repeated START (R2)
    put(EV_START); do_start();
    chk("R1 busy", busy_o, 1);
    chk("R1 addr_phase", addr_phase_o, 1);
    chk("R1 bit_cnt", bit_cnt_o, 0);
    do_byte(8'hA4);
    chk("R5 addr drop", addr_phase_o, 0);
    chk("R5 wrap", bit_cnt_o, 0);
    do_byte(8'h3C);
    put(EV_RSTART); do_start();
    chk("R2 busy", busy_o, 1);
    chk("R2 addr_phase", addr_phase_o, 1);
    chk("R2 bit_cnt", bit_cnt_o, 0);
    do_byte(8'hA5);
    put(EV_STOP); do_stop();
    chk("R3 busy", busy_o, 0);
    chk("R3 addr", addr_phase_o, 0);
    hold(10);

    // R4: STOP inside a byte
    put(EV_START); do_start();
    do_bit(1'b1); do_bit(1'b0); do_bit(1'b1);
    chk("R5 partial count", bit_cnt_o, 3);
    put(EV_ABORT); do_stop();
    chk("R4 busy", busy_o, 0);
    chk("R4 bit_cnt", bit_cnt_o, 0);
    hold(10);

    // R8 R6: stretch with SDA toggling while SCL low
    put(EV_START); do_start();
    for (int i = 0; i < 4; i++) do_bit(i[0]);
    for (int i = 0; i < 50; i++) begin
      sda_r = ~sda_r; hold(8);
    end
    chk("R6 count kept", bit_cnt_o, 4);
    hold(400);
    chk("R8 busy after stretch", busy_o, 1);
    chk("R8 count after stretch", bit_cnt_o, 4);
    put(EV_BYTE);
    for (int i = 0; i < 5; i++) do_bit(1'b1);
    chk("R8 resumed wrap", bit_cnt_o, 0);
    put(EV_STOP); do_stop();
    hold(10);

    // R7: timeout with limit 10
    put(EV_START); do_start();
    do_bit(1'b1); do_bit(1'b0);
    put(EV_TIMEOUT);
    sda_r = 1'b1; hold(Q);
    scl_r = 1'b1; hold(40);
    chk("R7 busy cleared", busy_o, 0);
    chk("R7 count cleared", bit_cnt_o, 0);
    hold(40);

    // R7: limit 25, 18-cycle high period does not fire
    limit_r = 16'd25;
    put(EV_START); do_start();
    do_bit(1'b0);
    sda_r = 1'b1; hold(Q);
    scl_r = 1'b1; hold(18);
    chk("R7 below limit busy", busy_o, 1);
    chk("R7 below limit count", bit_cnt_o, 1);
    scl_r = 1'b0; hold(Q);
    chk("R5 long high counts one", bit_cnt_o, 2);
    put(EV_TIMEOUT);
    scl_r = 1'b1; hold(40);
    chk("R7 limit 25 fired", busy_o, 0);

    // R7: limit 0 disables
    limit_r = 16'd0;
    put(EV_START); do_start();
    sda_r = 1'b1; hold(Q);
    scl_r = 1'b1; hold(60);
    chk("R7 disabled busy", busy_o, 1);
    scl_r = 1'b0; hold(Q);
    chk("R7 disabled count", bit_cnt_o, 1);
    put(EV_ABORT); do_stop();
    limit_r = 16'd10;
    hold(20);

    chk("R3 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule